// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the serial-side front end of a small non-volatile memory. It watches a chip-select period on a four-wire serial bus in clock modes 0 and 3. It splits the bit stream into an 8-bit command byte, a 16-bit address field and data bytes, and it turns six command codes into requests for the rest of the device. For reads it fetches bytes from a 1K x 8 array through an asynchronous read port. It streams them out on the serial output and moves to the next address after every byte.

All serial pins are sampled by a fast system clock, and edges of the serial clock are found inside the block. A hold input can freeze a transfer in the middle of a byte and release it later. Raising chip select always throws away the frame in progress. Programming, status storage and protection checks sit outside this block, which only reports complete bytes and command pulses to them.

Top module: `spi_mem_frontend`

## Requirements
- R1: While chip select is low, the serial input is taken on each rising serial-clock edge, most significant bit first. The first 8 bits of a frame form the command byte.
- R2: The serial output changes only after a falling serial-clock edge, most significant bit first. Its enable is low whenever chip select is high.
- R3: Command 06h gives one single-cycle `wren_req` pulse, and command 04h gives one single-cycle `wrdi_req` pulse. Bits after the command byte are ignored until chip select rises. At most one request output is high in any cycle.
- R4: Command 03h is followed by a 16-bit address, of which only the low 10 bits are used. D7 of the addressed byte is driven from the falling edge that follows the 24th rising edge of the frame.
- R5: While clocking continues, a read outputs the following addresses in turn, and address 3FFh is followed by 000h.
- R6: Command 05h drives `status_in` from the falling edge after the 8th rising edge. It repeats that byte, sampled again at each byte boundary, for as long as clocking continues.
- R7: After command 02h and its address, every complete byte gives a one-cycle `wr_req`. It carries that byte in `wr_data` and the byte's address in `wr_addr`. That address starts at the received address and goes up by one per byte, wrapping over 10 bits.
- R8: After command 01h, every complete byte gives a one-cycle `wrsr_req` with that byte in `wrsr_data`.
- R9: Any other command byte produces no request, and the output enable stays low until chip select rises.
- R10: While `hold_n` is low, serial-clock edges and the serial input are ignored and the output enable is low. After release with the serial clock low, the transfer continues with the next bit.
- R11: Chip select going high, including during hold, abandons the frame. The next frame starts again with a command byte.
- R12: Frames work with the serial clock idling low (mode 0) and idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transfer freeze, active low |
| status_in | input | 8 | Status byte supplied by the device |
| rd_data | input | 8 | Array read data for `rd_addr` (asynchronous) |
| so | output | 1 | Serial data out (0 when not enabled) |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |
| rd_addr | output | 10 | Array read address |
| wren_req | output | 1 | Enable-writes command pulse |
| wrdi_req | output | 1 | Disable-writes command pulse |
| wr_req | output | 1 | Data byte received for the array |
| wr_addr | output | 10 | Array address of `wr_data` |
| wr_data | output | 8 | Received data byte |
| wrsr_req | output | 1 | Status byte received |
| wrsr_data | output | 8 | Received status byte |

## Verification
The assertions assume that `cs_n`, `sck`, `si` and `hold_n` are already synchronous to `clk`. They also assume that each serial-clock level lasts at least two system clocks, and that `hold_n` changes only while the serial clock is low. The stimulus meets these by changing pins only on the falling system-clock edge and by holding each serial-clock level for four cycles. Hold is always entered and left with the serial clock low. Random frames draw the address, the unused upper address bits, the clock mode and the burst length from a seeded generator. Directed frames cover the address wrap, hold during the address and during read data, chip select rising inside hold, and an unknown command.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_BITS = 8;
  localparam int ADDR_FIELD_BITS = 16;
  localparam int ADDR_LAST_CNT = CMD_BITS + ADDR_FIELD_BITS - 1;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_IDLE} phase_t;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_WREN, CMD_WRDI, CMD_READ, CMD_WRITE, CMD_RDSR, CMD_WRSR
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] code);
    case (code)
      8'h06:   return CMD_WREN;
      8'h04:   return CMD_WRDI;
      8'h03:   return CMD_READ;
      8'h02:   return CMD_WRITE;
      8'h05:   return CMD_RDSR;
      8'h01:   return CMD_WRSR;
      default: return CMD_NONE;
    endcase
  endfunction

  function automatic logic cmd_streams_out(input cmd_t c);
    return (c == CMD_READ) || (c == CMD_RDSR);
  endfunction
endpackage

// File: rtl/spi_edge_gate.sv
module spi_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic hold_n,
  output logic rise_ev,
  output logic fall_ev
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign rise_ev = sck & ~sck_q & hold_n;
  assign fall_ev = ~sck & sck_q & hold_n;

  assert_edges_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_ev && fall_ev));
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] load_data,
  output logic         tx_bit,
  output logic         active
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      active <= 1'b0;
    end else if (clear) begin
      active <= 1'b0;
    end else if (load) begin
      sr     <= load_data;
      active <= 1'b1;
    end else if (shift) begin
      sr     <= {sr[W-2:0], 1'b0};
    end
  end

  assign tx_bit = sr[W-1];

  // output bit moves only after a load or a shift request
  assert_so_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(load) && !$past(shift)) |-> $stable(tx_bit));
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_mem_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic [7:0]        status_in,
  input  logic [7:0]        rd_data,
  output logic              so,
  output logic              so_oe,
  output logic [MEM_AW-1:0] rd_addr,
  output logic              wren_req,
  output logic              wrdi_req,
  output logic              wr_req,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wrsr_req,
  output logic [7:0]        wrsr_data
);
  localparam int CNT_W = $clog2(ADDR_LAST_CNT + 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_LAST_CNT);

  logic rise_ev, fall_ev;
  phase_t phase;
  cmd_t cmd;
  logic [CNT_W-1:0] cnt;
  logic [2:0] bidx;
  logic [BYTE_W-2:0] in_sr;
  logic [MEM_AW-1:0] addr;
  logic tx_bit, tx_active;

  // named internal events
  logic [BYTE_W-1:0] byte_in;
  logic cmd_done, addr_done, byte_done;
  logic tx_load, tx_shift;
  cmd_t cmd_now;

  assign byte_in   = {in_sr, si};
  assign cmd_now   = decode_cmd(byte_in);
  assign cmd_done  = rise_ev && phase == PH_CMD && cnt == CMD_LAST;
  assign addr_done = rise_ev && phase == PH_ADDR && cnt == ADDR_LAST;
  assign byte_done = rise_ev && phase == PH_DATA && bidx == 3'd7;
  assign tx_load   = fall_ev && !cs_n && phase == PH_DATA && bidx == 3'd0
                     && cmd_streams_out(cmd);
  assign tx_shift  = fall_ev && !cs_n && phase == PH_DATA && bidx != 3'd0;

  spi_edge_gate u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck), .hold_n(hold_n),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  spi_tx_shifter #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(cs_n), .load(tx_load), .shift(tx_shift),
    .load_data((cmd == CMD_RDSR) ? status_in : rd_data),
    .tx_bit(tx_bit), .active(tx_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD; cmd <= CMD_NONE; cnt <= '0; bidx <= '0;
      in_sr <= '0; addr <= '0;
      wren_req <= 1'b0; wrdi_req <= 1'b0; wr_req <= 1'b0; wrsr_req <= 1'b0;
      wr_addr <= '0; wr_data <= '0; wrsr_data <= '0;
    end else begin
      wren_req <= 1'b0; wrdi_req <= 1'b0; wr_req <= 1'b0; wrsr_req <= 1'b0;
      if (cs_n) begin
        phase <= PH_CMD; cmd <= CMD_NONE; cnt <= '0; bidx <= '0;
      end else if (rise_ev) begin
        in_sr <= byte_in[BYTE_W-2:0];
        case (phase)
          PH_CMD: begin
            cnt <= cnt + 1'b1;
            if (cmd_done) begin
              cmd  <= cmd_now;
              bidx <= '0;
              case (cmd_now)
                CMD_WREN:             begin wren_req <= 1'b1; phase <= PH_IDLE; end
                CMD_WRDI:             begin wrdi_req <= 1'b1; phase <= PH_IDLE; end
                CMD_READ, CMD_WRITE:  phase <= PH_ADDR;
                CMD_RDSR, CMD_WRSR:   phase <= PH_DATA;
                default:              phase <= PH_IDLE;
              endcase
            end
          end
          PH_ADDR: begin
            cnt  <= cnt + 1'b1;
            addr <= {addr[MEM_AW-2:0], si};
            if (addr_done) begin
              phase <= PH_DATA;
              bidx  <= '0;
            end
          end
          PH_DATA: begin
            bidx <= bidx + 1'b1;
            if (byte_done) begin
              case (cmd)
                CMD_WRITE: begin
                  wr_req  <= 1'b1;
                  wr_addr <= addr;
                  wr_data <= byte_in;
                  addr    <= addr + 1'b1;
                end
                CMD_READ: addr <= addr + 1'b1;
                CMD_WRSR: begin
                  wrsr_req  <= 1'b1;
                  wrsr_data <= byte_in;
                end
                default: ;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = addr;
  assign so_oe   = tx_active & ~cs_n & hold_n;
  assign so      = so_oe & tx_bit;

  assert_one_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_req, wrdi_req, wr_req, wrsr_req}));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase) == PH_DATA && !$stable(rd_addr))
      |-> rd_addr == MEM_AW'($past(rd_addr) + 1'b1));

  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !so_oe);

  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> ($stable(in_sr) && $stable(addr) && $stable(bidx) && $stable(cnt)));

  assert_cs_abandon_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase == PH_CMD && cnt == '0 && !so_oe));
endmodule

// File: tb/spi_mem_frontend_test.sv
module spi_mem_frontend_test;
  localparam int H = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cs_n, sck, si, hold_n;
  logic [7:0] status_in, rd_data, wr_data, wrsr_data;
  logic so, so_oe, wren_req, wrdi_req, wr_req, wrsr_req;
  logic [9:0] rd_addr, wr_addr;

  spi_mem_frontend uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .status_in(status_in), .rd_data(rd_data), .so(so), .so_oe(so_oe),
    .rd_addr(rd_addr), .wren_req(wren_req), .wrdi_req(wrdi_req),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrsr_req(wrsr_req), .wrsr_data(wrsr_data)
  );

  function automatic logic [7:0] mem_f(input logic [9:0] a);
    return 8'(a * 13 + 7) ^ {6'b0, a[9:8]};
  endfunction
  function automatic logic [9:0] wrap_add(input logic [15:0] a, input int k);
    return 10'(a[9:0] + k);
  endfunction

  assign rd_data = mem_f(rd_addr);

  int n_chk = 0, n_fail = 0;
  int n_wren = 0, n_wrdi = 0, n_wr = 0, n_wrsr = 0, n_oe_bad = 0;
  logic [9:0] wr_log_a [0:7];
  logic [7:0] wr_log_d [0:7];
  logic idle_hi = 1'b0;

  always @(posedge clk) begin
    if (wren_req) n_wren++;
    if (wrdi_req) n_wrdi++;
    if (wrsr_req) n_wrsr++;
    if (wr_req) begin
      if (n_wr < 8) begin wr_log_a[n_wr] = wr_addr; wr_log_d[n_wr] = wr_data; end
      n_wr++;
    end
    if (so_oe && (cs_n || !hold_n)) n_oe_bad++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_start();
    @(negedge clk); sck = idle_hi; wait_n(2);
    cs_n = 1'b0; wait_n(H);
  endtask

  task automatic frame_end();
    @(negedge clk); sck = idle_hi; wait_n(H);
    cs_n = 1'b1; wait_n(H);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic all_oe);
    all_oe = 1'b1;
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk); sck = 1'b0; si = tx[b];
      wait_n(H);
      rx[b] = so; all_oe = all_oe & so_oe;
      sck = 1'b1;
      wait_n(H);
    end
  endtask

  task automatic hold_pause(input int toggles, input string req);
    @(negedge clk); sck = 1'b0; wait_n(H);
    hold_n = 1'b0; wait_n(2);
    for (int t = 0; t < toggles; t++) begin
      si = 1'($urandom); sck = ~sck; wait_n(H);
      chk(req, so_oe, 1'b0);
    end
    sck = 1'b0; wait_n(H);
    hold_n = 1'b1; wait_n(2);
  endtask

  task automatic do_read(input logic [15:0] a, input int nb, input int hold_at, input string req);
    logic [7:0] rx; logic oe;
    frame_start();
    xbyte(8'h03, rx, oe);
    xbyte(a[15:8], rx, oe);
    if (hold_at == 1) hold_pause(4, "R10");
    xbyte(a[7:0], rx, oe);
    for (int k = 0; k < nb; k++) begin
      xbyte(8'h5A, rx, oe);
      chk(req, rx, mem_f(wrap_add(a, k)));
      chk(req, oe, 1'b1);
      if (hold_at == 2 && k == 0) hold_pause(3, "R10");
    end
    frame_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rx; logic oe; int w0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1; status_in = 8'hA6;
    wait_n(5); rst_n = 1'b1; wait_n(3);
    // reset state
    chk("R2 reset oe", so_oe, 1'b0);
    chk("R3 reset req", {wren_req, wrdi_req, wr_req, wrsr_req}, 4'b0);

    // R3: enable / disable pulses, trailing bits ignored
    frame_start(); xbyte(8'h06, rx, oe); xbyte(8'h03, rx, oe); xbyte(8'h05, rx, oe);
    chk("R3 no output after 06h", oe, 1'b0); frame_end();
    chk("R3 wren count", n_wren, 1);
    frame_start(); xbyte(8'h04, rx, oe); xbyte(8'h01, rx, oe); frame_end();
    chk("R3 wrdi count", n_wrdi, 1);
    chk("R3 no stray wrsr", n_wrsr, 0);

    // R4, R1: directed read, upper address bits set
    do_read(16'hFC12, 3, 0, "R4 read");
    // R5: wrap from 3FFh
    do_read(16'h03FE, 4, 0, "R5 wrap");
    // R12: mode 3
    idle_hi = 1'b1;
    do_read(16'h0155, 2, 0, "R12 mode3 read");
    idle_hi = 1'b0;

    // R6: status repeated, resampled at byte boundary
    frame_start(); xbyte(8'h05, rx, oe);
    xbyte(8'h00, rx, oe); chk("R6 status", rx, 8'hA6); chk("R6 oe", oe, 1'b1);
    status_in = 8'h3C;
    xbyte(8'h00, rx, oe); chk("R6 status again", rx, 8'h3C);
    frame_end();

    // R7, R1: write bytes with wrapping address
    w0 = n_wr;
    frame_start(); xbyte(8'h02, rx, oe); xbyte(8'hAB, rx, oe); xbyte(8'hFF, rx, oe);
    xbyte(8'h96, rx, oe); xbyte(8'h1E, rx, oe);
    chk("R7 no output on write", oe, 1'b0);
    frame_end();
    chk("R7 count", n_wr - w0, 2);
    chk("R7 addr0", wr_log_a[w0], 10'h3FF); chk("R1 data0 msb first", wr_log_d[w0], 8'h96);
    chk("R7 addr1", wr_log_a[w0+1], 10'h000); chk("R7 data1", wr_log_d[w0+1], 8'h1E);

    // R8: status write byte
    frame_start(); xbyte(8'h01, rx, oe); xbyte(8'h8C, rx, oe); frame_end();
    chk("R8 count", n_wrsr, 1); chk("R8 data", wrsr_data, 8'h8C);

    // R9: unknown command
    w0 = n_wr + n_wrsr + n_wren + n_wrdi;
    frame_start(); xbyte(8'hA5, rx, oe); xbyte(8'h03, rx, oe); xbyte(8'h00, rx, oe);
    chk("R9 silent", oe, 1'b0); frame_end();
    chk("R9 no req", n_wr + n_wrsr + n_wren + n_wrdi, w0);

    // R10: hold inside address and inside read data
    do_read(16'h0321, 2, 1, "R10 hold addr");
    do_read(16'h00F0, 2, 2, "R10 hold data");

    // R11: chip select rises during hold; next frame starts fresh
    frame_start(); xbyte(8'h03, rx, oe); xbyte(8'h01, rx, oe);
    @(negedge clk); sck = 1'b0; wait_n(H); hold_n = 1'b0; wait_n(H);
    cs_n = 1'b1; wait_n(H); hold_n = 1'b1; wait_n(H);
    chk("R11 oe after abandon", so_oe, 1'b0);
    frame_start(); xbyte(8'h05, rx, oe); xbyte(8'h00, rx, oe); frame_end();
    chk("R11 fresh frame", rx, 8'h3C);

    // random reads
    for (int it = 0; it < 8; it++) begin
      idle_hi = 1'($urandom);
      do_read(16'($urandom), 2 + int'($urandom_range(0, 2)), int'($urandom_range(0, 2)),
              "R5 random read");
    end
    chk("R2 oe only when selected and not held", n_oe_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule